// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block produces the four gate commands for one full bridge. The commands are upper and lower switch for leg 1, and upper and lower switch for leg 2. The block takes an enable, two direction bits and a chop request from an external current regulator. From these it sets the drive mode of each leg. Each leg is then moved towards its mode through a sequencer that never lets the two switches of one leg conduct together. Every change-over inside a leg passes through a programmable dead interval with both switches off.

Chopping uses slow decay. While the chop request is high in a driving direction, the leg that was pulling low releases its lower switch. After the dead interval, that leg's upper switch closes, so the load current circulates through both upper switches with synchronous rectification. When the request drops, the rectifying upper switch opens first. The lower switch recloses only after another dead interval. All gate outputs come from registers. The dead interval is the parameter `DEAD_CYC`, in clock cycles, and must be at least 1.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With `en_i` low, all four gate outputs are 0 one cycle later and stay 0, whatever the direction and chop inputs are.
- R2: Enable high with `dir1_i`=0 and `dir2_i`=0 selects the lower brake: `ls1_o` and `ls2_o` end up 1, and both upper gates end up 0.
- R3: Enable high with `dir1_i`=1 and `dir2_i`=0 selects forward: `hs1_o`=1 and `ls2_o`=1 (output 1 high, output 2 low).
- R4: Enable high with `dir1_i`=0 and `dir2_i`=1 selects reverse: `ls1_o`=1 and `hs2_o`=1.
- R5: Enable high with both direction bits 1 selects the upper brake (`hs1_o`=`hs2_o`=1). `chop_i` has no effect in either brake mode.
- R6: The upper and lower gate of the same leg are never 1 in the same cycle.
- R7: After a gate of a leg falls, neither gate of that leg rises until that leg has had exactly `DEAD_CYC` register cycles with both gates 0. The rise then happens in the next cycle if the leg is still required to conduct.
- R8: A chop request in forward or reverse turns off the conducting lower gate. After the dead interval it turns on the upper gate of that same leg. The other leg's upper gate is not disturbed.
- R9: When the chop request ends, the rectifying upper gate turns off first. The lower gate of that leg returns after a further dead interval.
- R10: Input changes made while a leg is inside its dead interval are held. The mode present at the end of the interval is the one applied, and intermediate modes leave no trace on the outputs.
- R11: During and after reset all gates are 0. The first turn-on after reset needs no dead interval and appears one cycle after enable is sampled.
- R12: The outputs are registered: a change of inputs sampled at a clock edge takes effect on the outputs at that edge and never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Bridge enable; low opens all switches |
| dir1_i | input | 1 | Direction bit for output 1 |
| dir2_i | input | 1 | Direction bit for output 2 |
| chop_i | input | 1 | Chop request from the current regulator |
| hs1_o | output | 1 | Upper gate, leg 1 |
| ls1_o | output | 1 | Lower gate, leg 1 |
| hs2_o | output | 1 | Upper gate, leg 2 |
| ls2_o | output | 1 | Lower gate, leg 2 |

## Verification
The hardest case to reach from the ports is an input change that lands inside a running dead interval. Examples are a direction reversal undone two cycles later, or a chop pulse shorter than the interval. In these cases the mode applied at the end must be the latest one, and the earlier ones must leave no trace. Directed sequences toggle the inputs at spacings below `DEAD_CYC`. The random phase then changes the inputs every few cycles with the bench's dead interval set to five cycles, so most changes fall mid-interval. A cycle-by-cycle reference model compares all four gates each cycle.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int unsigned NUM_LEGS = 2;

    // Drive mode requested for one leg of the bridge
    typedef enum logic [1:0] {
        LEG_FLOAT = 2'b00,
        LEG_HIGH  = 2'b01,
        LEG_LOW   = 2'b10
    } leg_cmd_e;

endpackage

// File: rtl/hbg_decode.sv
module hbg_decode
    import hbg_pkg::*;
(
    input  logic     en_i,
    input  logic     dir1_i,
    input  logic     dir2_i,
    input  logic     chop_i,
    output leg_cmd_e cmd_o [NUM_LEGS]
);

    // R1..R5, R8: mode decode with slow-decay substitution of the low leg
    always_comb begin
        cmd_o[0] = LEG_FLOAT;
        cmd_o[1] = LEG_FLOAT;
        if (en_i) begin
            case ({dir1_i, dir2_i})
                2'b00: begin
                    cmd_o[0] = LEG_LOW;
                    cmd_o[1] = LEG_LOW;
                end
                2'b10: begin
                    cmd_o[0] = LEG_HIGH;
                    cmd_o[1] = chop_i ? LEG_HIGH : LEG_LOW;
                end
                2'b01: begin
                    cmd_o[0] = chop_i ? LEG_HIGH : LEG_LOW;
                    cmd_o[1] = LEG_HIGH;
                end
                default: begin
                    cmd_o[0] = LEG_HIGH;
                    cmd_o[1] = LEG_HIGH;
                end
            endcase
        end
    end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 8
)(
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_e cmd_i,
    output logic     hs_o,
    output logic     ls_o
);

    localparam int unsigned CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] GAP_FULL = CW'(DEAD_CYC);

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [CW-1:0] wait_cnt;
    } leg_st_t;

    leg_st_t st_d, st_q;

    logic want_hs, want_ls, leaving;

    always_comb begin
        st_d    = st_q;
        want_hs = (cmd_i == LEG_HIGH);
        want_ls = (cmd_i == LEG_LOW);
        leaving = (st_q.hs && !want_hs) || (st_q.ls && !want_ls);
        if (leaving) begin
            // open both switches and arm the dead interval
            st_d.hs       = 1'b0;
            st_d.ls       = 1'b0;
            st_d.wait_cnt = GAP_LOAD;
        end else if (!st_q.hs && !st_q.ls) begin
            if (st_q.wait_cnt != '0) begin
                // R10: the mode is re-read only once the interval has run out
                st_d.wait_cnt = st_q.wait_cnt - 1'b1;
            end else begin
                st_d.hs = want_hs;
                st_d.ls = want_ls;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o = st_q.hs;
    assign ls_o = st_q.ls;

    // Checker support: consecutive cycles with the leg fully open (saturating)
    logic [CW-1:0] a_idle_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_idle_q <= GAP_FULL;
        end else if (st_q.hs || st_q.ls) begin
            a_idle_q <= '0;
        end else if (a_idle_q != GAP_FULL) begin
            a_idle_q <= a_idle_q + 1'b1;
        end
    end

    a_r6_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));

    a_r7_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_o) || $rose(ls_o)) |-> (a_idle_q == GAP_FULL));

    a_r10_held_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_o && !ls_o && a_idle_q < GAP_FULL && cmd_i != LEG_FLOAT) |=> (!hs_o && !ls_o) || (a_idle_q == GAP_FULL));

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 8
)(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dir1_i,
    input  logic dir2_i,
    input  logic chop_i,
    output logic hs1_o,
    output logic ls1_o,
    output logic hs2_o,
    output logic ls2_o
);

    leg_cmd_e leg_cmd [NUM_LEGS];
    logic     leg_hs  [NUM_LEGS];
    logic     leg_ls  [NUM_LEGS];

    hbg_decode i_decode (
        .en_i   (en_i),
        .dir1_i (dir1_i),
        .dir2_i (dir2_i),
        .chop_i (chop_i),
        .cmd_o  (leg_cmd)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg #(
            .DEAD_CYC (DEAD_CYC)
        ) i_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd_i (leg_cmd[g]),
            .hs_o  (leg_hs[g]),
            .ls_o  (leg_ls[g])
        );
    end

    assign hs1_o = leg_hs[0];
    assign ls1_o = leg_ls[0];
    assign hs2_o = leg_hs[1];
    assign ls2_o = leg_ls[1];

    a_r1_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !(hs1_o || ls1_o || hs2_o || ls2_o));

    a_r5_lower_brake_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dir1_i && !dir2_i) |=> (!hs1_o && !hs2_o));

    a_r8_fwd_chop_no_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && dir1_i && !dir2_i && chop_i) |=> !$rose(ls2_o));

    a_r8_rev_chop_no_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dir1_i && dir2_i && chop_i) |=> !$rose(ls1_o));

endmodule

// File: tb/test_hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module test_hbridge_gate_ctrl;

    localparam int DT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, d1 = 1'b0, d2 = 1'b0, chop = 1'b0;
    logic hs1, ls1, hs2, ls2;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state: per leg expected gates and open-cycle count
    bit exp_hs [2];
    bit exp_ls [2];
    int offc   [2];

    always #5 clk = ~clk;

    hbridge_gate_ctrl #(.DEAD_CYC(DT)) i_hbridge_gate_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .dir1_i (d1),
        .dir2_i (d2),
        .chop_i (chop),
        .hs1_o  (hs1),
        .ls1_o  (ls1),
        .hs2_o  (hs2),
        .ls2_o  (ls2)
    );

    // 0 = open, 1 = upper closed, 2 = lower closed
    function automatic int wanted(int leg);
        bit mine, other;
        if (!en) return 0;
        mine  = (leg == 0) ? d1 : d2;
        other = (leg == 0) ? d2 : d1;
        if (mine) return 1;
        if (chop && other) return 1;
        return 2;
    endfunction

    function automatic void model_reset();
        for (int g = 0; g < 2; g++) begin
            exp_hs[g] = 0; exp_ls[g] = 0; offc[g] = DT;
        end
    endfunction

    function automatic void model_edge();
        int w [2];
        for (int g = 0; g < 2; g++) w[g] = wanted(g);
        for (int g = 0; g < 2; g++) begin
            if (exp_hs[g] || exp_ls[g]) begin
                if ((exp_hs[g] && w[g] != 1) || (exp_ls[g] && w[g] != 2)) begin
                    exp_hs[g] = 0; exp_ls[g] = 0; offc[g] = 0;
                end
            end else if (offc[g] + 1 >= DT) begin
                if (w[g] == 1) exp_hs[g] = 1;
                else if (w[g] == 2) exp_ls[g] = 1;
                else offc[g] = DT;
            end else begin
                offc[g] = offc[g] + 1;
            end
        end
    endfunction

    function automatic string mode_tag();
        if (!en) return "R1";
        if (d1 && d2) return "R5";
        if (!d1 && !d2) return "R2";
        if (chop) return "R8";
        return d1 ? "R3" : "R4";
    endfunction

    task automatic compare(input string tag);
        logic [3:0] got, want;
        got  = {hs1, ls1, hs2, ls2};
        want = {exp_hs[0], exp_ls[0], exp_hs[1], exp_ls[1]};
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s gates hs1,ls1,hs2,ls2 actual=%b expected=%b at %0t", tag, got, want, $time);
        end
        total++;
        if ((hs1 && ls1) || (hs2 && ls2)) begin
            bad++;
            $display("FAIL R6 leg overlap actual=%b expected no leg with both set", got);
        end
    endtask

    // inputs are changed at negedge; model follows the posedge; compare at negedge
    task automatic step(input string tag);
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic drive(input bit e, input bit a, input bit b, input bit c);
        en = e; d1 = a; d2 = b; chop = c;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R12 watchdog finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0421));
        model_reset();
        // R11: reset state with active-looking inputs
        drive(1, 1, 0, 0);
        repeat (3) begin @(negedge clk); compare("R11"); end
        drive(0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run(2, "R11");

        // R11/R3: first turn-on straight after reset, no dead interval
        drive(1, 1, 0, 0);
        run(4, "R3");
        // R8 then R9: chop on and off, longer than the dead interval
        drive(1, 1, 0, 1);
        run(2 * DT + 2, "R8");
        drive(1, 1, 0, 0);
        run(2 * DT + 2, "R9");
        // R4/R7: reversal passes through the dead interval on both legs
        drive(1, 0, 1, 0);
        run(DT + 3, "R7");
        run(2, "R4");
        drive(1, 0, 1, 1);
        run(2 * DT + 2, "R8");
        drive(1, 0, 1, 0);
        run(2 * DT + 2, "R9");
        // R2/R5: brakes, chop has no effect
        drive(1, 0, 0, 0);
        run(DT + 3, "R2");
        drive(1, 0, 0, 1);
        run(DT + 2, "R5");
        drive(1, 1, 1, 0);
        run(DT + 3, "R5");
        drive(1, 1, 1, 1);
        run(DT + 2, "R5");
        // R1: disable with every direction pattern
        for (int p = 0; p < 4; p++) begin
            drive(0, p[0], p[1], p[0]);
            run(2, "R1");
            drive(1, p[1], p[0], 0);
            run(DT + 2, "R12");
        end
        // R10: changes inside the dead interval
        drive(1, 1, 0, 0);
        run(DT + 3, "R3");
        drive(1, 0, 1, 0);
        run(2, "R10");
        drive(1, 1, 0, 0);
        run(1, "R10");
        drive(1, 1, 1, 0);
        run(DT + 3, "R10");
        drive(1, 1, 0, 1);
        run(2, "R10");
        drive(1, 1, 0, 0);
        run(DT + 3, "R10");
        drive(1, 1, 0, 1);
        run(1, "R10");
        drive(1, 1, 0, 0);
        run(DT + 3, "R10");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                drive(($urandom_range(0, 7) != 0), $urandom_range(0, 1),
                      $urandom_range(0, 1), $urandom_range(0, 1));
            end
            step(mode_tag());
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule